// File: doc/BRIEF.md
# Time-of-day alarm comparator

This block sits beside a real-time clock's timekeeping logic. The timekeeper supplies the current seconds, minutes and hours bytes, and it pulses an update strobe once per second after those bytes have advanced. On each strobe the comparator sets an update-done flag. It then checks the three current bytes against three programmable alarm bytes, and on a match it also sets an alarm flag. Any alarm byte can be made a wildcard that matches every value of its field.

Both the time bytes and the alarm bytes can be held as packed decimal (BCD) or as plain binary. The hour bytes can be kept in 24-hour form or in 12-hour form with a PM marker. Before comparing, the block brings both hours into the same form.

An interrupt summary flag and an interrupt line rise only when a flag that was clear becomes set while that flag's enable is on. A wake pulse accompanies every alarm hit that occurs while the alarm interrupt is enabled. A single clear strobe empties the flags and drops the interrupt.

Top module: `tod_alarm_unit`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, update_flag, alarm_flag, irq_flag, irq and wake are all 0.
- R2: A tick cycle sets update_flag in the following cycle, whatever the time and alarm bytes hold.
- R3: A tick cycle sets alarm_flag in the following cycle exactly when every non-wildcard alarm field equals its normalised current field. Otherwise alarm_flag keeps its value.
- R4: An alarm byte whose bits [7:6] are both 1 is a wildcard and matches any current value. With all three alarm bytes wildcards, every tick sets alarm_flag.
- R5: With bin_mode = 0, each byte is BCD: tens digit in bits [7:4], units in bits [3:0]. With bin_mode = 1, each byte is an unsigned binary number. For example, in 12-hour mode alarm hour 8'h12 matches current hour 8'h00 only in BCD, and alarm hour 8'h0C matches it in binary.
- R6: With hr24 = 0, the hour bytes use bit 7 as PM. Bits [6:0] are decoded, taken modulo 12, and 12 is added when PM is set, so 12 AM equals hour 0 and 12 PM equals PM 0. With hr24 = 1, the whole hour byte is decoded with no PM bit.
- R7: irq_flag and irq rise in the cycle after a tick only if the tick sets a flag that was clear and that flag's enable (update_en for update_flag, alarm_en for alarm_flag) is 1. A tick that finds a flag already set raises nothing for it.
- R8: flag_clr clears update_flag, alarm_flag, irq_flag and irq in the next cycle. If tick arrives in the same cycle, the clear is applied first and the tick's flags count as newly set.
- R9: wake is a one-cycle pulse in the cycle after a tick that matches while alarm_en is 1. This holds even if alarm_flag was already set.
- R10: Without tick or flag_clr, all flags hold their values and irq does not rise, even when the enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Once-per-second update strobe |
| flag_clr | input | 1 | Clears all flags and the interrupt |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit 7 |
| update_en | input | 1 | Interrupt enable for update_flag |
| alarm_en | input | 1 | Interrupt enable for alarm_flag and wake |
| update_flag | output | 1 | Update-done flag |
| alarm_flag | output | 1 | Alarm-match flag |
| irq_flag | output | 1 | Interrupt summary flag |
| irq | output | 1 | Interrupt request line |
| wake | output | 1 | One-cycle wake request |

## Verification
The hardest case to reach is a tick that finds a flag already set while its enable has just been turned on. The interrupt must stay low there, which separates the newness rule from a plain flag-and-enable rule. The bench sets the flag with its enable off, turns the enable on during idle cycles, and ticks again without clearing. Hour equivalences across modes (12 AM against 0, and the same bytes read as BCD and as binary) are driven with chosen bytes. Random vectors drawn from a small pool then make matches, wildcards and same-cycle clear-plus-tick common.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int TOD_BYTE_W = 8;
  localparam int TOD_FIELDS = 3;
  localparam int FIELD_SEC  = 0;
  localparam int FIELD_MIN  = 1;
  localparam int FIELD_HOUR = 2;

  // field value after mode normalisation, plus wildcard marker
  typedef struct packed {
    logic                  wild;
    logic [TOD_BYTE_W-1:0] val;
  } tod_norm_t;

  typedef struct packed {
    logic alarm;
    logic update;
  } tod_flags_t;
endpackage

// File: rtl/tod_field_norm.sv
module tod_field_norm
  import tod_alarm_pkg::*;
#(
  parameter bit WILD_OK   = 1'b1,
  parameter int HALF_DAY  = 12,
  parameter int DEC_RADIX = 10
) (
  input  logic [TOD_BYTE_W-1:0] raw,
  input  logic                  bin_mode,
  input  logic                  twelve_hr,
  output tod_norm_t             norm
);
  localparam int W   = TOD_BYTE_W;
  localparam int NIB = W / 2;

  logic [W-1:0] body;
  logic [W-1:0] dec;
  logic [W-1:0] base;
  logic [W-1:0] wrapped;

  always_comb begin
    // PM marker is not part of the number in 12-hour form
    body    = twelve_hr ? {1'b0, raw[W-2:0]} : raw;
    dec     = W'(body[W-1:NIB]) * W'(DEC_RADIX) + W'(body[NIB-1:0]);
    base    = bin_mode ? body : dec;
    wrapped = base % W'(HALF_DAY);
    if (twelve_hr) norm.val = wrapped + (raw[W-1] ? W'(HALF_DAY) : '0);
    else           norm.val = base;
  end

  generate
    if (WILD_OK) begin : g_wild
      assign norm.wild = &raw[W-1:W-2];
    end else begin : g_nowild
      assign norm.wild = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic [TOD_FIELDS-1:0][TOD_BYTE_W-1:0] cur_bytes,
  input  logic [TOD_FIELDS-1:0][TOD_BYTE_W-1:0] alm_bytes,
  input  logic                                  bin_mode,
  input  logic                                  hr24,
  output logic                                  hit
);
  logic [TOD_FIELDS-1:0] field_ok;

  generate
    for (genvar i = 0; i < TOD_FIELDS; i++) begin : g_field
      localparam bit IS_HOUR = (i == FIELD_HOUR);
      logic      twelve;
      tod_norm_t cur_n;
      tod_norm_t alm_n;

      assign twelve = IS_HOUR ? ~hr24 : 1'b0;

      tod_field_norm #(.WILD_OK(1'b0)) u_cur (
        .raw(cur_bytes[i]), .bin_mode(bin_mode), .twelve_hr(twelve), .norm(cur_n));
      tod_field_norm #(.WILD_OK(1'b1)) u_alm (
        .raw(alm_bytes[i]), .bin_mode(bin_mode), .twelve_hr(twelve), .norm(alm_n));

      assign field_ok[i] = alm_n.wild | (~cur_n.wild & (alm_n.val == cur_n.val));
    end
  endgenerate

  assign hit = &field_ok;
endmodule

// File: rtl/tod_flag_bank.sv
module tod_flag_bank
  import tod_alarm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic flag_clr,
  input  logic update_en,
  input  logic alarm_en,
  output logic update_flag,
  output logic alarm_flag,
  output logic irq_flag,
  output logic irq,
  output logic wake
);
  tod_flags_t flags_q, kept, raised, fresh, flags_d;
  logic irq_q, line_q, wake_q, irq_kept, irq_d, wake_d;

  always_comb begin
    kept          = flag_clr ? '0 : flags_q;
    irq_kept      = flag_clr ? 1'b0 : irq_q;
    raised.update = tick;
    raised.alarm  = tick & hit;
    fresh         = tod_flags_t'(raised & ~kept);
    flags_d       = tod_flags_t'(kept | raised);
    irq_d         = irq_kept | (fresh.update & update_en) | (fresh.alarm & alarm_en);
    wake_d        = raised.alarm & alarm_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
      line_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= irq_d;
      line_q  <= irq_d;
      wake_q  <= wake_d;
    end
  end

  assign update_flag = flags_q.update;
  assign alarm_flag  = flags_q.alarm;
  assign irq_flag    = irq_q;
  assign irq         = line_q;
  assign wake        = wake_q;

  AST_UPD_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    tick |=> update_flag); // R2
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !tick) |=> (!update_flag && !alarm_flag && !irq && !irq_flag)); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (update_flag || alarm_flag)); // R7
  AST_WAKE_WITH_ALARM: assert property (@(posedge clk) disable iff (rst)
    wake |-> alarm_flag); // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !flag_clr) |=> $stable({update_flag, alarm_flag, irq})); // R10
  AST_IRQ_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tick)); // R7
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  flag_clr,
  input  logic [TOD_BYTE_W-1:0] cur_sec,
  input  logic [TOD_BYTE_W-1:0] cur_min,
  input  logic [TOD_BYTE_W-1:0] cur_hour,
  input  logic [TOD_BYTE_W-1:0] alm_sec,
  input  logic [TOD_BYTE_W-1:0] alm_min,
  input  logic [TOD_BYTE_W-1:0] alm_hour,
  input  logic                  bin_mode,
  input  logic                  hr24,
  input  logic                  update_en,
  input  logic                  alarm_en,
  output logic                  update_flag,
  output logic                  alarm_flag,
  output logic                  irq_flag,
  output logic                  irq,
  output logic                  wake
);
  localparam int W = TOD_BYTE_W;

  logic [TOD_FIELDS-1:0][W-1:0] cur_bytes;
  logic [TOD_FIELDS-1:0][W-1:0] alm_bytes;
  logic                         hit;

  always_comb begin
    cur_bytes[FIELD_SEC]  = cur_sec;
    cur_bytes[FIELD_MIN]  = cur_min;
    cur_bytes[FIELD_HOUR] = cur_hour;
    alm_bytes[FIELD_SEC]  = alm_sec;
    alm_bytes[FIELD_MIN]  = alm_min;
    alm_bytes[FIELD_HOUR] = alm_hour;
  end

  tod_alarm_match u_match (
    .cur_bytes(cur_bytes), .alm_bytes(alm_bytes),
    .bin_mode(bin_mode), .hr24(hr24), .hit(hit));

  tod_flag_bank u_flags (
    .clk(clk), .rst(rst), .tick(tick), .hit(hit), .flag_clr(flag_clr),
    .update_en(update_en), .alarm_en(alarm_en),
    .update_flag(update_flag), .alarm_flag(alarm_flag),
    .irq_flag(irq_flag), .irq(irq), .wake(wake));

  AST_ALL_WILD_FIRES: assert property (@(posedge clk) disable iff (rst)
    (tick && (&alm_sec[W-1:W-2]) && (&alm_min[W-1:W-2]) && (&alm_hour[W-1:W-2]))
    |=> alarm_flag); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!update_flag && !alarm_flag && !irq_flag && !irq && !wake)); // R1
endmodule

// File: tb/tb_tod_alarm_unit.sv
module tb_tod_alarm_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, flag_clr = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
  logic bin_mode = 1'b0, hr24 = 1'b1, update_en = 1'b0, alarm_en = 1'b0;
  logic update_flag, alarm_flag, irq_flag, irq, wake;

  int n_vec = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  bit m_upd, m_alm, m_irq, m_wake;
  bit k_upd, k_alm, k_irq, m_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm_unit dut (
    .clk(clk), .rst(rst), .tick(tick), .flag_clr(flag_clr),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .bin_mode(bin_mode), .hr24(hr24), .update_en(update_en), .alarm_en(alarm_en),
    .update_flag(update_flag), .alarm_flag(alarm_flag),
    .irq_flag(irq_flag), .irq(irq), .wake(wake));

  function automatic int field_value(int b, bit bin, bit twelve);
    int n, v;
    n = twelve ? (b % 128) : b;
    v = bin ? n : (n / 16) * 10 + (n % 16);
    if (twelve) begin
      v = v % 12;
      if (b >= 128) v = v + 12;
    end
    return v;
  endfunction

  function automatic bit field_hit(int a, int c, bit bin, bit twelve);
    if (a >= 192) return 1'b1;
    return field_value(a, bin, twelve) == field_value(c, bin, twelve);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_upd <= 0; m_alm <= 0; m_irq <= 0; m_wake <= 0;
    end else begin
      m_hit = field_hit(alm_sec, cur_sec, bin_mode, 0) &&
              field_hit(alm_min, cur_min, bin_mode, 0) &&
              field_hit(alm_hour, cur_hour, bin_mode, !hr24);
      k_upd = flag_clr ? 0 : m_upd;
      k_alm = flag_clr ? 0 : m_alm;
      k_irq = flag_clr ? 0 : m_irq;
      m_upd  <= k_upd | tick;
      m_alm  <= k_alm | (tick && m_hit);
      m_irq  <= k_irq | (tick && !k_upd && update_en) | (tick && m_hit && !k_alm && alarm_en);
      m_wake <= tick && m_hit && alarm_en;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_model(string tag);
    n_vec++;
    check(tag, "update_flag", update_flag, m_upd);
    check(tag, "alarm_flag", alarm_flag, m_alm);
    check(tag, "irq_flag", irq_flag, m_irq);
    check(tag, "irq", irq, m_irq);
    check(tag, "wake", wake, m_wake);
  endtask

  task automatic apply(string tag, bit t, bit c);
    tick = t; flag_clr = c;
    @(posedge clk);
    @(negedge clk);
    tick = 0; flag_clr = 0;
    compare_model(tag);
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    cur_sec = s; cur_min = m; cur_hour = h;
  endtask

  task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    alm_sec = s; alm_min = m; alm_hour = h;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  function automatic logic [7:0] pick_byte();
    int r = $urandom_range(0, 9);
    case (r)
      0: return 8'h00;
      1: return 8'h12;
      2: return 8'h0C;
      3: return 8'h80;
      4: return 8'h92;
      5: return 8'h81;
      6: return 8'h01;
      7: return 8'h59;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", "update_flag", update_flag, 0);
    check("R1", "irq", irq, 0);
    rst = 0;
    apply("R1", 0, 0);
    check("R1", "all outputs", {update_flag, alarm_flag, irq_flag, irq, wake}, 0);

    // R2: tick without match, enables off
    set_time(8'h10, 8'h20, 8'h08); set_alarm(8'h11, 8'h20, 8'h08);
    apply("R2", 1, 0);
    check("R2", "update_flag", update_flag, 1);
    check("R3", "alarm_flag no match", alarm_flag, 0);
    check("R2", "irq disabled", irq, 0);

    // R3: exact match, then minute mismatch
    apply("R8", 0, 1);
    alm_sec = 8'h10;
    apply("R3", 1, 0);
    check("R3", "alarm_flag match", alarm_flag, 1);
    apply("R8", 0, 1);
    alm_min = 8'h21;
    apply("R3", 1, 0);
    check("R3", "alarm_flag minute differs", alarm_flag, 0);

    // R4: wildcards
    set_alarm(8'hC0, 8'hFF, 8'hC5);
    for (int k = 0; k < 4; k++) begin
      apply("R8", 0, 1);
      set_time(8'(k * 7), 8'(k * 13), 8'(k + 3));
      apply("R4", 1, 0);
      check("R4", "all wild fires", alarm_flag, 1);
    end
    apply("R8", 0, 1);
    set_time(8'h33, 8'h44, 8'h05); set_alarm(8'hC7, 8'h44, 8'h05);
    apply("R4", 1, 0);
    check("R4", "sec wild", alarm_flag, 1);

    // R5: BCD versus binary in 12-hour mode
    hr24 = 0; bin_mode = 0;
    apply("R8", 0, 1);
    set_time(8'h00, 8'h00, 8'h00); set_alarm(8'h00, 8'h00, 8'h12);
    apply("R5", 1, 0);
    check("R5", "bcd 12AM eq 0", alarm_flag, 1);
    apply("R8", 0, 1);
    bin_mode = 1;
    apply("R5", 1, 0);
    check("R5", "binary 0x12 ne 0", alarm_flag, 0);
    apply("R8", 0, 1);
    alm_hour = 8'h0C;
    apply("R5", 1, 0);
    check("R5", "binary 12AM eq 0", alarm_flag, 1);

    // R6: PM bit and 24-hour
    bin_mode = 0;
    apply("R8", 0, 1);
    cur_hour = 8'h81; alm_hour = 8'h01;
    apply("R6", 1, 0);
    check("R6", "PM1 ne AM1", alarm_flag, 0);
    apply("R8", 0, 1);
    alm_hour = 8'h81;
    apply("R6", 1, 0);
    check("R6", "PM1 eq PM1", alarm_flag, 1);
    apply("R8", 0, 1);
    cur_hour = 8'h92; alm_hour = 8'h80;
    apply("R6", 1, 0);
    check("R6", "12PM eq PM0", alarm_flag, 1);
    apply("R8", 0, 1);
    hr24 = 1; cur_hour = 8'h12; alm_hour = 8'h00;
    apply("R6", 1, 0);
    check("R6", "24h 12 ne 0", alarm_flag, 0);

    // R7 / R10: newness rule
    apply("R8", 0, 1);
    set_time(8'h01, 8'h02, 8'h03); set_alarm(8'h05, 8'h02, 8'h03);
    apply("R7", 1, 0);
    update_en = 1;
    apply("R10", 0, 0);
    check("R10", "enable alone no irq", irq, 0);
    apply("R7", 1, 0);
    check("R7", "already set no irq", irq, 0);
    alarm_en = 1; alm_sec = 8'h01;
    apply("R7", 1, 0);
    check("R7", "new alarm irq", irq, 1);
    check("R9", "wake pulse", wake, 1);
    apply("R9", 0, 0);
    check("R9", "wake one cycle", wake, 0);
    apply("R9", 1, 0);
    check("R9", "wake on repeat hit", wake, 1);
    check("R10", "irq held", irq, 1);

    // R8: clear with tick, then plain clear
    apply("R8", 1, 1);
    check("R8", "clr+tick irq new", irq, 1);
    check("R8", "clr+tick flags", {update_flag, alarm_flag}, 3);
    apply("R8", 0, 1);
    check("R8", "clr empties", {update_flag, alarm_flag, irq_flag, irq}, 0);
    alarm_en = 0;
    apply("R9", 1, 0);
    check("R9", "no wake when disabled", wake, 0);
    for (int k = 0; k < 3; k++) begin
      update_en = k[0]; alarm_en = ~k[0];
      apply("R10", 0, 0);
    end

    // random mix against the model (R3, R7)
    for (int k = 0; k < 600; k++) begin
      bin_mode = ($urandom_range(0, 3) == 0);
      hr24 = $urandom_range(0, 1);
      update_en = $urandom_range(0, 1); alarm_en = $urandom_range(0, 1);
      set_time(pick_byte(), pick_byte(), pick_byte());
      set_alarm($urandom_range(0, 1) ? cur_sec : pick_byte(),
                $urandom_range(0, 2) != 0 ? cur_min : 8'hC0,
                $urandom_range(0, 2) != 0 ? cur_hour : pick_byte());
      apply("R3", $urandom_range(0, 1), $urandom_range(0, 6) == 0);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule